// File: doc/BRIEF.md
# Instrument Status Event Reporting Unit

This block collects status events for a programmable supply with up to four outputs and for the command handler that drives it. Each output provides six condition inputs. These report voltage limiting, current limiting, an over-voltage trip, an over-current trip, an over-temperature trip and a fatal fault. The inputs are synchronised, and their rising edges are latched into a sticky limit event register for that output. A standard event register latches power-on and command-error events. Every event register has an enable mask. The masked bits are OR-reduced into one summary bit per register in a status byte. A service-request mask then decides which summary bits raise the request output.

A host reaches the registers through a small request port. A request is accepted in any cycle where `req_valid_i` is high, because `req_ready_o` is always high and the port never applies back-pressure. A read returns its data with `rsp_valid_o` exactly one cycle later. The response side has no ready signal, so the host must take the data in that cycle. Reading an event register returns its contents and clears it in the same operation. Enable masks can be read without side effects.

Top module: `status_event_unit`

## Requirements
- R1: After reset, the standard event register holds 0x80 (power-on, bit 7). All limit event registers and all masks hold 0, so `status_byte_o` and `srq_o` are 0.
- R2: The condition bus bit `lim_cond_i[6*n+k]` belongs to output n+1 (address n). For k = 0..5 the conditions are voltage limit, current limit, over-voltage, over-current, over-temperature and fatal fault. A rising edge of condition k sets bit k of that output's limit event register for k<5, and bit 6 for k=5. Bits 5 and 7 always read 0.
- R3: A read at address 0..3 returns that limit event register and clears it. A condition held high does not set its bit again after the clear. A second read returns 0.
- R4: An event that arrives in the same cycle as a clearing read of its register is kept in the register. The read returns the value from before the event.
- R5: The enable masks are read/write, 8 bits wide, and return the written value on any number of reads. The addresses are 4..7 for the limit masks, 9 for the standard mask and 10 for the service-request mask.
- R6: Status byte bit n is set exactly when the limit event register and limit mask at address n share a set bit. Clearing either one drops the bit by the next sampling point.
- R7: A one-cycle pulse on `cmd_err_i` sets bit 5 of the standard event register (address 8, read clears it). Bits 6 and 1 always read 0. Status byte bit 5 is the OR of the standard register ANDed with its mask.
- R8: `srq_o` is high exactly when the status byte, excluding bit 6, shares a set bit with the service-request mask. Status byte bit 6 mirrors `srq_o`. Bits 7 and 4 are 0.
- R9: A read request produces `rsp_valid_o` one cycle later, with the data in `rsp_rdata_o`. Address 11 returns the status byte. Writes to addresses 0..3, 8 and 11 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| lim_cond_i | input | 24 | Asynchronous condition levels, 6 per output |
| cmd_err_i | input | 1 | Command syntax error pulse, synchronous |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Request ready, always 1 |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 4 | Register address |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata_o | output | 8 | Read data |
| status_byte_o | output | 8 | Status byte summary |
| srq_o | output | 1 | Service request |

## Verification
The assertions take three things about the inputs for granted. `cmd_err_i` is a synchronous single-cycle pulse. Each condition level stays stable long enough to pass the two-stage synchroniser. The host takes every response in the cycle it appears. The stimulus drives all inputs on the falling edge. It holds each condition for at least four cycles before sampling, and it spaces requests at least one cycle apart. It also lines up the one coincidence case on purpose, a clearing read in the same cycle as an event.

// File: rtl/sevt_pkg.sv
package sevt_pkg;
  localparam int ADDR_W    = 4;
  localparam int REG_W     = 8;
  localparam int CONDS     = 6;
  localparam logic [ADDR_W-1:0] A_LSR0 = 4'h0;
  localparam logic [ADDR_W-1:0] A_LEN0 = 4'h4;
  localparam logic [ADDR_W-1:0] A_STD  = 4'h8;
  localparam logic [ADDR_W-1:0] A_SEN  = 4'h9;
  localparam logic [ADDR_W-1:0] A_SRE  = 4'hA;
  localparam logic [ADDR_W-1:0] A_STB  = 4'hB;
  localparam logic [REG_W-1:0] LIM_VALID = 8'h5F;
  localparam logic [REG_W-1:0] STD_VALID = 8'hBD;
  localparam int STB_STD = 5;
  localparam int STB_RQS = 6;

  function automatic logic [REG_W-1:0] map_conds(input logic [CONDS-1:0] c);
    return {1'b0, c[5], 1'b0, c[4:0]};
  endfunction
endpackage

// File: rtl/sevt_cond_edge.sv
module sevt_cond_edge #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) chain[0] <= '0;
    else         chain[0] <= lvl_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i) begin
      if (!rst_ni) chain[s] <= '0;
      else         chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= chain[STAGES-1];
  end

  assign rise_o = chain[STAGES-1] & ~prev_q;

  // R3
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o & $past(rise_o)) == '0);
endmodule

// File: rtl/sevt_event_reg.sv
module sevt_event_reg #(
  parameter int           W      = 8,
  parameter logic [W-1:0] VALID  = '1,
  parameter logic [W-1:0] RSTVAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) q_o <= RSTVAL & VALID;
    else         q_o <= (clr_i ? '0 : q_o) | (set_i & VALID);
  end

  // R3
  clear_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i == '0) |=> q_o == '0);
  // R4
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (q_o & $past(q_o)) == $past(q_o));
  // R2
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o & ~VALID) == '0);
endmodule

// File: rtl/status_event_unit.sv
module status_event_unit
  import sevt_pkg::*;
#(
  parameter int NUM_OUT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_OUT*CONDS-1:0] lim_cond_i,
  input  logic                     cmd_err_i,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic                     req_write_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [REG_W-1:0]         req_wdata_i,
  output logic                     rsp_valid_o,
  output logic [REG_W-1:0]         rsp_rdata_o,
  output logic [REG_W-1:0]         status_byte_o,
  output logic                     srq_o
);
  localparam int NCOND = NUM_OUT * CONDS;

  logic [NCOND-1:0] rise;
  logic [REG_W-1:0] lsr_q [NUM_OUT];
  logic [REG_W-1:0] len_q [NUM_OUT];
  logic [NUM_OUT-1:0] lim_sum;
  logic [REG_W-1:0] std_q, sen_q, sre_q, rd_mux;
  logic rd_acc, wr_acc, std_clr;

  assign req_ready_o = 1'b1;
  assign rd_acc = req_valid_i && !req_write_i;
  assign wr_acc = req_valid_i &&  req_write_i;

  sevt_cond_edge #(.W(NCOND), .STAGES(SYNC_STAGES)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lim_cond_i), .rise_o(rise));

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_out
    logic clr_n, wen_n;
    assign clr_n = rd_acc && (req_addr_i == A_LSR0 + ADDR_W'(n));
    assign wen_n = wr_acc && (req_addr_i == A_LEN0 + ADDR_W'(n));

    sevt_event_reg #(.W(REG_W), .VALID(LIM_VALID), .RSTVAL('0)) u_lsr (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_i(map_conds(rise[n*CONDS +: CONDS])),
      .clr_i(clr_n), .q_o(lsr_q[n]));

    always_ff @(posedge clk_i) begin
      if (!rst_ni)    len_q[n] <= '0;
      else if (wen_n) len_q[n] <= req_wdata_i;
    end

    assign lim_sum[n] = |(lsr_q[n] & len_q[n]);
  end

  assign std_clr = rd_acc && (req_addr_i == A_STD);

  sevt_event_reg #(.W(REG_W), .VALID(STD_VALID), .RSTVAL(8'h80)) u_std (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i({2'b00, cmd_err_i, 5'b00000}),
    .clr_i(std_clr), .q_o(std_q));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sen_q <= '0;
      sre_q <= '0;
    end else if (wr_acc) begin
      if (req_addr_i == A_SEN) sen_q <= req_wdata_i;
      if (req_addr_i == A_SRE) sre_q <= req_wdata_i;
    end
  end

  logic [REG_W-1:0] stb_base;
  always_comb begin
    stb_base = '0;
    stb_base[NUM_OUT-1:0] = lim_sum;
    stb_base[STB_STD] = |(std_q & sen_q);
  end

  assign srq_o = |(stb_base & sre_q);
  always_comb begin
    status_byte_o = stb_base;
    status_byte_o[STB_RQS] = srq_o;
  end

  always_comb begin
    rd_mux = '0;
    for (int n = 0; n < NUM_OUT; n++) begin
      if (req_addr_i == A_LSR0 + ADDR_W'(n)) rd_mux = lsr_q[n];
      if (req_addr_i == A_LEN0 + ADDR_W'(n)) rd_mux = len_q[n];
    end
    case (req_addr_i)
      A_STD:   rd_mux = std_q;
      A_SEN:   rd_mux = sen_q;
      A_SRE:   rd_mux = sre_q;
      A_STB:   rd_mux = status_byte_o;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd_acc;
      if (rd_acc) rsp_rdata_o <= rd_mux;
    end
  end

  // R9
  rsp_follows_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc |=> rsp_valid_o);
  // R9
  no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_acc |=> !rsp_valid_o);
  // R5
  sre_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && req_addr_i == A_SRE) |=> sre_q == $past(req_wdata_i));
  // R7
  cmd_err_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_i |=> std_q[5]);
endmodule

// File: tb/status_event_unit_tb_top.sv
module status_event_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NO = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NO*6-1:0] cond = '0;
  logic cmd_err = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, srq;
  logic [7:0] rsp_rdata, stb;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_event_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lim_cond_i(cond), .cmd_err_i(cmd_err),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .status_byte_o(stb), .srq_o(srq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk("R9 rsp_valid", {7'b0, rsp_valid}, 8'h01);
    d = rsp_rdata;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", stb, 8'h00);
    chk("R1 srq", {7'b0, srq}, 8'h00);
    chk("R9 ready", {7'b0, req_ready}, 8'h01);
    rd(4'h4, v); chk("R1 lim mask", v, 8'h00);
    rd(4'h8, v); chk("R1 power-on", v, 8'h80);
    rd(4'h8, v); chk("R3 std cleared", v, 8'h00);

    // R2/R3/R6/R8 sweep over outputs and conditions
    for (int n = 0; n < NO; n++) begin
      wr(4'hA, 8'(1 << n));
      for (int k = 0; k < 6; k++) begin
        int bp;
        bp = (k == 5) ? 6 : k;
        cond[n*6 + k] = 1'b1;
        repeat (4) @(negedge clk);
        for (int m = 0; m < 8; m++) begin
          wr(4'(4 + n), 8'(1 << m));
          chk("R6 summary", {7'b0, stb[n]}, {7'b0, (m == bp)});
          chk("R8 srq", {7'b0, srq}, {7'b0, (m == bp)});
          chk("R8 bit6 mirrors", {7'b0, stb[6]}, {7'b0, srq});
        end
        for (int o = 0; o < NO; o++)
          if (o != n) begin rd(4'(o), v); chk("R2 other output", v, 8'h00); end
        rd(4'(n), v); chk("R2 bit map", v, 8'(1 << bp));
        chk("R6 drop after clear", {7'b0, stb[n]}, 8'h00);
        repeat (3) @(negedge clk);
        rd(4'(n), v); chk("R3 level no reset", v, 8'h00);
        wr(4'(4 + n), 8'h00);
        cond[n*6 + k] = 1'b0;
        repeat (4) @(negedge clk);
      end
    end
    wr(4'hA, 8'h00);

    // R5 enable readback, no side effects
    for (int a = 4; a <= 10; a++) begin
      if (a == 8) continue;
      wr(4'(a), 8'(8'hA5 ^ a));
      rd(4'(a), v); chk("R5 readback", v, 8'(8'hA5 ^ a));
      rd(4'(a), v); chk("R5 readback again", v, 8'(8'hA5 ^ a));
      wr(4'(a), 8'h00);
    end

    // R9 writes to read-only addresses are ignored
    cond[0] = 1; repeat (4) @(negedge clk);
    wr(4'h0, 8'hFF); wr(4'h8, 8'hFF); wr(4'hB, 8'hFF);
    rd(4'h0, v); chk("R9 ro write lsr", v, 8'h01);
    rd(4'h8, v); chk("R9 ro write std", v, 8'h00);
    cond[0] = 0; repeat (4) @(negedge clk);

    // R7 command error and summary
    cmd_err = 1; @(negedge clk); cmd_err = 0;
    chk("R7 no summary when masked", stb, 8'h00);
    wr(4'h9, 8'h20);
    chk("R7 summary bit5", stb, 8'h20);
    wr(4'hA, 8'h20);
    chk("R8 srq from std", {7'b0, srq}, 8'h01);
    chk("R8 status with rqs", stb, 8'h60);
    wr(4'hA, 8'h40);
    chk("R8 bit6 of mask ignored", {7'b0, srq}, 8'h00);
    rd(4'hB, v); chk("R9 status read", v, 8'h20);
    rd(4'h8, v); chk("R7 cmd error bit", v, 8'h20);
    chk("R6 std summary drops", stb, 8'h00);
    wr(4'h9, 8'h00); wr(4'hA, 8'h00);

    // R4 event coincident with clearing read (standard register)
    cmd_err = 1; req_valid = 1; req_write = 0; req_addr = 4'h8;
    @(negedge clk);
    cmd_err = 0; req_valid = 0;
    chk("R4 read returns old", rsp_rdata, 8'h00);
    rd(4'h8, v); chk("R4 std event kept", v, 8'h20);

    // R4 coincident on limit register
    cond[6*2 + 3] = 1;
    @(negedge clk); @(negedge clk);
    rd(4'h2, v); chk("R4 lim read old", v, 8'h00);
    rd(4'h2, v); chk("R4 lim event kept", v, 8'h08);
    cond[6*2 + 3] = 0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule